// File: doc/BRIEF.md
# CRC32C Accumulate, Store and Test Engine

This block sits in a DMA data path and runs a Castagnoli CRC over byte streams under control of a per-transfer command. A command carries an opcode, a byte count, an optional seed and an optional reference value. The opcode selects one of two data behaviours. Move forwards every source byte to an output stream. CRC-only consumes the bytes without forwarding them. The opcode also selects one of three ends: keep accumulating, store the result, or test the result against a reference.

One running accumulator is shared by all six opcodes and survives from one command to the next. Long buffers can therefore be checked in pieces. Setting the seed flag restarts the accumulator from a given 32-bit value.

A location bit decides where a stored result or a test reference lives. With the bit at 0 it travels out of band: on the result port, or in the command. With the bit at 1 it travels inline as four bytes directly after the data. A failed test stops the engine, and the engine stays stopped until software clears the error or resets the block.

Top module: `crc32c_engine`

## Requirements
- R1: Accepted opcodes are 0x41, 0x42 and 0x43 (move with accumulate, test or store) and 0x81, 0x82 and 0x83 (CRC-only with accumulate, test or store). Any other opcode is still taken by the command port. It then raises `bad_op` for one cycle, starts no data phase, produces no output and leaves the accumulator unchanged, even when the seed flag is set.
- R2: The accumulator is a reflected CRC32C register with polynomial 0x82F63B78. Exactly `cmd_len` input bytes are folded into it, least significant bit first. The CRC value is the bitwise inverse of the register, so "123456789" from the reset state gives 0xE3069283.
- R3: After reset the register holds 0xFFFFFFFF. With `cmd_use_seed`=1 the register is loaded with `cmd_seed` before the first byte. With `cmd_use_seed`=0 it continues from the previous command, so data split across commands gives the same CRC as data sent in one command.
- R4: For opcodes 0x41, 0x42 and 0x43, each accepted data byte appears unchanged on `m_tdata` with `m_tvalid` one cycle after it is accepted. Opcodes 0x81, 0x82 and 0x83 raise no `m_tvalid` for data bytes.
- R5: For a store opcode with `cmd_inline`=0, `res_valid` pulses together with `done`, and `res_crc` carries the CRC value. No other opcode pulses `res_valid`.
- R6: For a store opcode with `cmd_inline`=1, the four CRC bytes follow the data on the output stream, least significant byte first. This holds for both store opcodes. `s_tready` stays low while these bytes are emitted.
- R7: For a test opcode with `cmd_inline`=0, the reference is `cmd_ref`. With `cmd_inline`=1, the reference is the four input bytes after the data, least significant byte first. Those bytes are neither folded into the CRC nor forwarded. The test passes when the reference equals the CRC value.
- R8: A failed test sets `halted`. While `halted` is set, `cmd_ready` and `s_tready` stay low. `halted` clears only through `clr_err` or `rst`, and the accumulator keeps its value across the halt.
- R9: `done` pulses once per valid command. It pulses in the cycle after the last data or reference byte is accepted, or together with the last appended CRC byte on the output stream. It also pulses when a failed test sets `halted`.
- R10: Accumulate opcodes (0x41, 0x81) only update the accumulator and pulse `done`, and never set `halted`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_err | input | 1 | Clears the halted error state |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine can take a command |
| cmd_op | input | 8 | Opcode |
| cmd_use_seed | input | 1 | Load seed into the accumulator first |
| cmd_seed | input | 32 | Seed value for the register |
| cmd_inline | input | 1 | Result or reference travels inline after the data |
| cmd_len | input | LEN_W | Number of data bytes |
| cmd_ref | input | 32 | Out-of-band reference CRC |
| s_tvalid | input | 1 | Input byte valid |
| s_tready | output | 1 | Engine accepts an input byte |
| s_tdata | input | 8 | Input byte |
| m_tvalid | output | 1 | Output byte valid |
| m_tdata | output | 8 | Output byte (forwarded data or CRC) |
| res_valid | output | 1 | Out-of-band result pulse |
| res_crc | output | 32 | Out-of-band CRC value |
| done | output | 1 | Command finished pulse |
| halted | output | 1 | CRC error, engine stopped |
| bad_op | output | 1 | Rejected opcode pulse |

## Verification
The bench runs every valid opcode with both location settings over lengths 0, 1, 4 and 9. It mixes seeded and unseeded commands, so a design that reset the accumulator per command, or folded the inline reference bytes into it, would produce wrong CRCs on the later commands. Zero-length commands check that a design does not wait for a byte that never comes. The inline store cases check byte order and that the bytes appear for the CRC-only store too. All 250 invalid opcodes are swept with the seed flag set, which catches a design that loads the seed or starts a data phase for a rejected command. Failed tests in both reference locations check that the halt blocks both ports, survives repeated commands and keeps the accumulator intact.

// File: rtl/crc32c_pkg.sv
package crc32c_pkg;

  localparam logic [31:0] CASTAGNOLI_REFL = 32'h82F63B78;
  localparam logic [31:0] ACC_RESET       = 32'hFFFF_FFFF;

  localparam logic [7:0] OPC_MOVE_ACC   = 8'h41;
  localparam logic [7:0] OPC_MOVE_TEST  = 8'h42;
  localparam logic [7:0] OPC_MOVE_STORE = 8'h43;
  localparam logic [7:0] OPC_ONLY_ACC   = 8'h81;
  localparam logic [7:0] OPC_ONLY_TEST  = 8'h82;
  localparam logic [7:0] OPC_ONLY_STORE = 8'h83;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_REFIN,
    ST_APPEND,
    ST_HALT
  } eng_state_t;

  typedef struct packed {
    logic valid;
    logic is_move;
    logic is_test;
    logic is_store;
  } op_info_t;

endpackage

// File: rtl/crc32c_step.sv
module crc32c_step #(
  parameter int          CRC_W  = 32,
  parameter int          DATA_W = 8,
  parameter logic [31:0] POLY   = 32'h82F63B78
) (
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [CRC_W-1:0]  crc_out
);
  localparam int PAD_W = CRC_W - DATA_W;

  logic [CRC_W-1:0] chain [0:DATA_W];

  assign chain[0] = crc_in ^ {{PAD_W{1'b0}}, data_in};

  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    assign chain[g+1] = chain[g][0] ? ((chain[g] >> 1) ^ POLY[CRC_W-1:0])
                                    : (chain[g] >> 1);
  end

  assign crc_out = chain[DATA_W];
endmodule

// File: rtl/crc_op_decode.sv
module crc_op_decode
  import crc32c_pkg::*;
(
  input  logic [7:0] op,
  output op_info_t   info
);
  always_comb begin
    info = '0;
    case (op)
      OPC_MOVE_ACC:   begin info.valid = 1'b1; info.is_move = 1'b1; end
      OPC_MOVE_TEST:  begin info.valid = 1'b1; info.is_move = 1'b1; info.is_test  = 1'b1; end
      OPC_MOVE_STORE: begin info.valid = 1'b1; info.is_move = 1'b1; info.is_store = 1'b1; end
      OPC_ONLY_ACC:   begin info.valid = 1'b1; end
      OPC_ONLY_TEST:  begin info.valid = 1'b1; info.is_test  = 1'b1; end
      OPC_ONLY_STORE: begin info.valid = 1'b1; info.is_store = 1'b1; end
      default:        info = '0;
    endcase
  end
endmodule

// File: rtl/crc32c_engine.sv
module crc32c_engine
  import crc32c_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_err,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [7:0]       cmd_op,
  input  logic             cmd_use_seed,
  input  logic [31:0]      cmd_seed,
  input  logic             cmd_inline,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic [31:0]      cmd_ref,
  input  logic             s_tvalid,
  output logic             s_tready,
  input  logic [7:0]       s_tdata,
  output logic             m_tvalid,
  output logic [7:0]       m_tdata,
  output logic             res_valid,
  output logic [31:0]      res_crc,
  output logic             done,
  output logic             halted,
  output logic             bad_op
);
  localparam int CRC_W      = 32;
  localparam int BYTE_W     = 8;
  localparam int WIRE_BYTES = CRC_W / BYTE_W;
  localparam int IDX_W      = $clog2(WIRE_BYTES);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WIRE_BYTES - 1);

  eng_state_t       state, nxt;
  logic [CRC_W-1:0] acc, acc_step, seed_sel, crc_val;
  logic [LEN_W-1:0] len_cnt;
  logic [IDX_W-1:0] idx;
  logic [CRC_W-1:0] ref_q;
  op_info_t         dec_info, info_q, cur_info;
  logic             inline_q, cur_inline;

  logic             accept, data_end, fin_go, test_fail;
  logic [CRC_W-1:0] end_acc, fin_acc, fin_ref;

  crc_op_decode u_dec (
    .op   (cmd_op),
    .info (dec_info)
  );

  crc32c_step #(
    .CRC_W  (CRC_W),
    .DATA_W (BYTE_W),
    .POLY   (CASTAGNOLI_REFL)
  ) u_step (
    .crc_in  (acc),
    .data_in (s_tdata),
    .crc_out (acc_step)
  );

  assign cmd_ready  = (state == ST_IDLE);
  assign s_tready   = (state == ST_DATA) || (state == ST_REFIN);
  assign accept     = cmd_ready && cmd_valid;
  assign seed_sel   = cmd_use_seed ? cmd_seed : acc;
  assign crc_val    = ~acc;
  assign cur_info   = (state == ST_IDLE) ? dec_info   : info_q;
  assign cur_inline = (state == ST_IDLE) ? cmd_inline : inline_q;

  // Next state and finish decision
  always_comb begin
    nxt       = state;
    data_end  = 1'b0;
    end_acc   = acc_step;
    fin_go    = 1'b0;
    fin_acc   = acc;
    fin_ref   = ref_q;
    test_fail = 1'b0;

    case (state)
      ST_IDLE: begin
        if (accept && dec_info.valid) begin
          if (cmd_len == '0) begin
            data_end = 1'b1;
            end_acc  = seed_sel;
          end else begin
            nxt = ST_DATA;
          end
        end
      end
      ST_DATA: begin
        if (s_tvalid && (len_cnt == LEN_W'(1))) begin
          data_end = 1'b1;
          end_acc  = acc_step;
        end
      end
      ST_REFIN: begin
        if (s_tvalid && (idx == IDX_LAST)) begin
          fin_go  = 1'b1;
          fin_acc = acc;
          fin_ref = {s_tdata, ref_q[CRC_W-1:BYTE_W]};
        end
      end
      ST_APPEND: begin
        if (idx == IDX_LAST) begin
          fin_go  = 1'b1;
          fin_acc = acc;
        end
      end
      ST_HALT: begin
        if (clr_err) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase

    if (data_end) begin
      if (cur_info.is_test && cur_inline) begin
        nxt = ST_REFIN;
      end else if (cur_info.is_store && cur_inline) begin
        nxt = ST_APPEND;
      end else begin
        fin_go  = 1'b1;
        fin_acc = end_acc;
        fin_ref = (state == ST_IDLE) ? cmd_ref : ref_q;
      end
    end

    if (fin_go) begin
      test_fail = cur_info.is_test && (fin_ref != ~fin_acc);
      nxt       = test_fail ? ST_HALT : ST_IDLE;
    end
  end

  // Registers
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      acc       <= ACC_RESET;
      len_cnt   <= '0;
      idx       <= '0;
      ref_q     <= '0;
      info_q    <= '0;
      inline_q  <= 1'b0;
      m_tvalid  <= 1'b0;
      m_tdata   <= '0;
      res_valid <= 1'b0;
      res_crc   <= '0;
      done      <= 1'b0;
      halted    <= 1'b0;
      bad_op    <= 1'b0;
    end else begin
      state     <= nxt;
      m_tvalid  <= 1'b0;
      res_valid <= 1'b0;
      done      <= 1'b0;
      bad_op    <= 1'b0;

      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (!dec_info.valid) begin
              bad_op <= 1'b1;
            end else begin
              info_q   <= dec_info;
              inline_q <= cmd_inline;
              len_cnt  <= cmd_len;
              ref_q    <= cmd_ref;
              idx      <= '0;
              acc      <= seed_sel;
            end
          end
        end
        ST_DATA: begin
          if (s_tvalid) begin
            acc     <= acc_step;
            len_cnt <= len_cnt - LEN_W'(1);
            if (info_q.is_move) begin
              m_tvalid <= 1'b1;
              m_tdata  <= s_tdata;
            end
          end
        end
        ST_REFIN: begin
          if (s_tvalid) begin
            ref_q <= {s_tdata, ref_q[CRC_W-1:BYTE_W]};
            idx   <= idx + IDX_W'(1);
          end
        end
        ST_APPEND: begin
          m_tvalid <= 1'b1;
          m_tdata  <= crc_val[idx*BYTE_W +: BYTE_W];
          idx      <= idx + IDX_W'(1);
        end
        ST_HALT: begin
          if (clr_err) halted <= 1'b0;
        end
        default: ;
      endcase

      if (fin_go) begin
        done <= 1'b1;
        if (cur_info.is_store && !cur_inline) begin
          res_valid <= 1'b1;
          res_crc   <= ~fin_acc;
        end
        if (test_fail) halted <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/crc32c_engine_chk.sv
module crc32c_engine_chk (
  input logic clk,
  input logic rst,
  input logic clr_err,
  input logic cmd_ready,
  input logic s_tready,
  input logic res_valid,
  input logic done,
  input logic halted,
  input logic bad_op
);
  AST_HALT_NO_CMD: assert property (@(posedge clk) disable iff (rst)
    halted |-> !cmd_ready); // R8
  AST_HALT_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    halted |-> !s_tready); // R8
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (halted && !clr_err) |=> halted); // R8
  AST_HALT_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(halted) |-> done); // R9
  AST_RESULT_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> done); // R5
  AST_BADOP_SILENT: assert property (@(posedge clk) disable iff (rst)
    bad_op |-> (!done && !res_valid && !s_tready)); // R1
endmodule

bind crc32c_engine crc32c_engine_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .clr_err   (clr_err),
  .cmd_ready (cmd_ready),
  .s_tready  (s_tready),
  .res_valid (res_valid),
  .done      (done),
  .halted    (halted),
  .bad_op    (bad_op)
);

// File: tb/crc32c_engine_tb_top.sv
`timescale 1ns/1ps
module crc32c_engine_tb_top;
  typedef logic [7:0] bq_t[$];

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr_err = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [7:0]  cmd_op = '0;
  logic        cmd_use_seed = 1'b0;
  logic [31:0] cmd_seed = '0;
  logic        cmd_inline = 1'b0;
  logic [15:0] cmd_len = '0;
  logic [31:0] cmd_ref = '0;
  logic        s_tvalid = 1'b0;
  logic        s_tready;
  logic [7:0]  s_tdata = '0;
  logic        m_tvalid;
  logic [7:0]  m_tdata;
  logic        res_valid;
  logic [31:0] res_crc;
  logic        done;
  logic        halted;
  logic        bad_op;

  always #2.5 clk = ~clk;

  crc32c_engine #(.LEN_W(16)) dut_i (
    .clk(clk), .rst(rst), .clr_err(clr_err),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_use_seed(cmd_use_seed), .cmd_seed(cmd_seed), .cmd_inline(cmd_inline),
    .cmd_len(cmd_len), .cmd_ref(cmd_ref),
    .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
    .m_tvalid(m_tvalid), .m_tdata(m_tdata),
    .res_valid(res_valid), .res_crc(res_crc),
    .done(done), .halted(halted), .bad_op(bad_op)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  // Monitor
  logic [7:0]  obytes[$];
  int          done_n, res_n, bad_n, done_cyc, olast_cyc, last_in_cyc;
  logic [31:0] res_v;
  logic [31:0] m_acc;
  logic [31:0] lcg = 32'h1234_5678;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (m_tvalid) begin obytes.push_back(m_tdata); olast_cyc = cyc; end
    if (done) begin done_n++; done_cyc = cyc; end
    if (res_valid) begin res_n++; res_v = res_crc; end
    if (bad_op) bad_n++;
  end

  function automatic logic [31:0] fold(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'h82F63B78) : (r >> 1);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    obytes.delete();
    done_n = 0; res_n = 0; bad_n = 0; done_cyc = -1; olast_cyc = -1; last_in_cyc = -1;
  endtask

  task automatic issue(input logic [7:0] op, input bit us, input logic [31:0] sd,
                       input bit inl, input int len, input logic [31:0] rf);
    cmd_valid = 1; cmd_op = op; cmd_use_seed = us; cmd_seed = sd;
    cmd_inline = inl; cmd_len = 16'(len); cmd_ref = rf;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic send(input logic [7:0] b);
    s_tvalid = 1; s_tdata = b;
    while (!s_tready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    s_tvalid = 0;
    last_in_cyc = cyc;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bq_t make_data(input int len);
    bq_t q;
    for (int i = 0; i < len; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      q.push_back(lcg[23:16]);
    end
    return q;
  endfunction

  // Runs one valid command, with the model predicting every output
  task automatic run(input logic [7:0] op, input bit us, input logic [31:0] sd,
                     input bit inl, input bq_t d, input bit corrupt, input string tag);
    bit mv = (op[7:4] == 4'h4);
    bit tst = (op[3:0] == 4'h2);
    bit sto = (op[3:0] == 4'h3);
    logic [31:0] exp_crc, rf;
    bq_t exp_out;
    if (us) m_acc = sd;
    foreach (d[i]) m_acc = fold(m_acc, d[i]);
    exp_crc = ~m_acc;
    rf = corrupt ? (exp_crc ^ 32'h0000_0100) : exp_crc;
    clear_mon();
    issue(op, us, sd, inl, d.size(), inl ? 32'hDEAD_BEEF : rf);
    foreach (d[i]) send(d[i]);
    if (tst && inl) for (int k = 0; k < 4; k++) send(rf[k*8 +: 8]);
    idle(8);
    if (mv) exp_out = d;
    if (sto && inl) for (int k = 0; k < 4; k++) exp_out.push_back(exp_crc[k*8 +: 8]);
    chk(done_n == 1, "R9", {tag, " done count"}, done_n, 1);
    chk(obytes.size() == exp_out.size(), mv ? "R4" : "R6", {tag, " output length"},
        obytes.size(), exp_out.size());
    if (obytes.size() == exp_out.size())
      foreach (exp_out[i])
        chk(obytes[i] == exp_out[i], (i >= d.size()) ? "R6" : "R4",
            {tag, " output byte"}, obytes[i], exp_out[i]);
    chk(res_n == ((sto && !inl) ? 1 : 0), "R5", {tag, " result pulses"}, res_n, (sto && !inl));
    if (sto && !inl) chk(res_v == exp_crc, "R2", {tag, " result crc"}, res_v, exp_crc);
    chk(halted == (tst && corrupt), tst ? "R7" : "R10", {tag, " halted"}, halted, (tst && corrupt));
    if (sto && inl)
      chk(done_cyc == olast_cyc, "R9", {tag, " done with last crc byte"}, done_cyc, olast_cyc);
    else if (d.size() > 0 || (tst && inl))
      chk(done_cyc == last_in_cyc, "R9", {tag, " done after last byte"}, done_cyc, last_in_cyc);
  endtask

  localparam logic [7:0] OPS [6] = '{8'h41, 8'h42, 8'h43, 8'h81, 8'h82, 8'h83};
  localparam int LENS [4] = '{0, 1, 4, 9};

  initial begin
    bq_t ascii, part_a, part_b, d;
    for (int i = 0; i < 9; i++) ascii.push_back(8'h31 + 8'(i));
    for (int i = 0; i < 4; i++) part_a.push_back(ascii[i]);
    for (int i = 4; i < 9; i++) part_b.push_back(ascii[i]);
    m_acc = 32'hFFFF_FFFF;
    clear_mon();
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // Reset state
    chk(cmd_ready == 1 && s_tready == 0, "R8", "reset ready pins", {cmd_ready, s_tready}, 2'b10);
    chk(halted == 0 && done == 0 && m_tvalid == 0 && res_valid == 0, "R9", "reset outputs",
        {halted, done, m_tvalid, res_valid}, 0);

    // R3: reset value as the start, check value of the standard string
    run(8'h83, 0, 0, 0, ascii, 0, "R3 unseeded check value");
    chk(res_v == 32'hE306_9283, "R2", "check value 123456789", res_v, 32'hE306_9283);

    // R3: split across two commands, no seed on the second
    run(8'h81, 1, 32'hFFFF_FFFF, 0, part_a, 0, "R3 split part a");
    run(8'h83, 0, 0, 0, part_b, 0, "R3 split part b");
    chk(res_v == 32'hE306_9283, "R3", "split check value", res_v, 32'hE306_9283);

    // Sweep opcodes x location x lengths, mixing seeded and continuing commands
    for (int o = 0; o < 6; o++)
      for (int l = 0; l < 2; l++)
        for (int n = 0; n < 4; n++) begin
          d = make_data(LENS[n]);
          run(OPS[o], (n % 2) == 0, lcg ^ 32'h5A5A_0000, l[0], d, 0, "sweep");
        end

    // R1: every invalid opcode is rejected, seed ignored
    for (int op = 0; op < 256; op++) begin
      logic [7:0] opb = 8'(op);
      if (opb == 8'h41 || opb == 8'h42 || opb == 8'h43 ||
          opb == 8'h81 || opb == 8'h82 || opb == 8'h83) continue;
      clear_mon();
      issue(opb, 1, 32'h0BAD_5EED, 0, 3, 0);
      chk(s_tready == 0, "R1", "no data phase on bad op", s_tready, 0);
      idle(3);
      chk(bad_n == 1 && done_n == 0 && obytes.size() == 0, "R1", "bad op response",
          {bad_n[7:0], done_n[7:0], 8'(obytes.size())}, 32'h0001_0000);
    end
    d = make_data(5);
    run(8'h83, 0, 0, 0, d, 0, "R1 accumulator untouched by bad ops");

    // R8: failed out-of-band test halts, then clr_err recovers
    d = make_data(6);
    run(8'h82, 0, 0, 0, d, 1, "R7 failing test oob");
    clear_mon();
    cmd_valid = 1; cmd_op = 8'h81; cmd_len = 16'd2; s_tvalid = 1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(cmd_ready == 0 && s_tready == 0 && halted == 1, "R8", "halt blocks ports",
          {cmd_ready, s_tready, halted}, 3'b001);
    end
    cmd_valid = 0; s_tvalid = 0;
    chk(done_n == 0, "R8", "no command while halted", done_n, 0);
    clr_err = 1;
    @(negedge clk);
    clr_err = 0;
    chk(halted == 0 && cmd_ready == 1, "R8", "clear releases halt", {halted, cmd_ready}, 2'b01);
    d = make_data(3);
    run(8'h43, 0, 0, 0, d, 0, "R8 accumulator kept across halt");

    // R7: failed inline test halts, reset recovers and restores the initial value
    d = make_data(4);
    run(8'h42, 0, 0, 1, d, 1, "R7 failing test inline");
    rst = 1;
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(halted == 0 && cmd_ready == 1, "R8", "reset releases halt", {halted, cmd_ready}, 2'b01);
    m_acc = 32'hFFFF_FFFF;
    run(8'h43, 0, 0, 1, ascii, 0, "R3 after reset inline store");
    chk(obytes.size() == 13 && {obytes[12], obytes[11], obytes[10], obytes[9]} == 32'hE306_9283,
        "R6", "inline check value order", obytes.size(), 13);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule